// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Cache

This block is a small read cache that gets set-associative behaviour out of one direct-mapped line array. The array holds `LINES` lines and is split into `LINES/WAYS` sets. Each set owns `WAYS` slots spread across the array. A lookup does not read all slots at once. It probes the slots of its set one per cycle, starting at slot 0, and stops at the first hit. After the last slot misses, the block asks the next level for the word through a simple fill port. It writes the returned word into one slot of the set and returns that word as a miss response.

Addresses are word addresses. The low `SET_W` bits pick the set, and every remaining bit above them is kept as the line's tag. Slot `i` of set `s` sits at array index `{i, s}`. A caller issues one request when `req_ready` is high and gets exactly one response pulse back. The response carries hit/miss, the data word, and the slot that served the request. A hit in slot `i` answers after `i+1` cycles. A miss answers one cycle after the fill word arrives.

Top module: `psa_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, and every line is invalid, so the first lookup of any address misses.
- R2: A request that hits in slot i gives `rsp_valid`=1, `rsp_hit`=1, `rsp_way`=i and the stored word exactly i+1 clock edges after the edge that accepted it.
- R3: `req_ready` is 0 from the edge after acceptance until the response cycle, and a `req_valid` presented while busy is neither accepted nor answered.
- R4: When all slots miss, `mem_req` rises exactly WAYS edges after acceptance with `mem_addr` equal to the request address. Both stay unchanged until `mem_valid` is seen.
- R5: The edge that sees `mem_valid` during a fill writes `mem_data` into the chosen slot. `rsp_valid`=1, `rsp_hit`=0, `rsp_data`=`mem_data` and `rsp_way`=the slot follow one edge later, and a later lookup of the same address hits in that slot.
- R6: On a miss, the fill goes to the lowest-numbered invalid slot of the set if one exists.
- R7: When all slots of a set are valid, the fill goes to a per-set rotating pointer. The pointer starts at 0 after reset and advances by one only when it was used. Sets do not share pointers.
- R8: The slot for probe i is array index {i, addr[SET_W-1:0]}, and a hit needs the full upper address (tag) to match. Addresses that share a set but differ in tag occupy different slots and never hit each other.
- R9: `rsp_valid` is a one-cycle pulse.
- R10: `mem_valid` while no fill is pending changes no stored line and causes no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Word address of the lookup |
| req_ready | output | 1 | High while idle; a request is taken on an edge where both are high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = hit, 0 = served by fill |
| rsp_data | output | DATA_W | Returned word |
| rsp_way | output | WAY_W | Slot that hit, or slot that was filled |
| mem_req | output | 1 | Fill request to the next level, held until served |
| mem_addr | output | ADDR_W | Address of the pending fill |
| mem_valid | input | 1 | Fill word present |
| mem_data | input | DATA_W | Fill word |

## Verification
Several kinds of internal fault show up at the ports. A corrupt probe counter or a wrong index concatenation moves a hit to the wrong slot number or latency, and the answer is visible in the same response. A bad valid bit or victim choice is silent at first. It appears one or more lookups later as an unexpected miss, a slot number that breaks the lowest-invalid or rotating order, or data that belongs to another address. The directed sequences therefore refill one set past its capacity and then look up the evicted and the surviving addresses. This catches a wrong replacement state within a few requests.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_FILL  = 2'd2
  } psa_state_e;
endpackage

// File: rtl/psa_line_array.sv
module psa_line_array #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/psa_rr_table.sv
module psa_rr_table #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             adv_en,
  output logic [WAY_W-1:0] ptr
);
  logic [WAY_W-1:0] ptr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             hit_set;
    logic [WAY_W-1:0] ptr_d;
    assign hit_set = adv_en && (set_idx == SET_W'(s));

    always_comb begin
      ptr_d = ptr_q[s];
      if (hit_set) ptr_d = ptr_q[s] + WAY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[s] <= '0;
      else        ptr_q[s] <= ptr_d;
    end
  end

  assign ptr = ptr_q[set_idx];
endmodule

// File: rtl/psa_probe_ctrl.sv
module psa_probe_ctrl
  import psa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic [SET_W-1:0]  rr_set,
  input  logic [WAY_W-1:0]  rr_ptr,
  output logic              rr_adv,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic [WAY_W-1:0]  rsp_way
);
  psa_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WAY_W-1:0]  probe_q, probe_d;
  logic              inv_seen_q, inv_seen_d;
  logic [WAY_W-1:0]  inv_way_q, inv_way_d;
  logic [WAY_W-1:0]  victim_q, victim_d;
  logic              use_rr_q, use_rr_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [WAY_W-1:0]  rsp_way_q, rsp_way_d;

  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic              probe_hit;
  logic              probe_last;
  logic              free_seen;
  logic [WAY_W-1:0]  free_way;
  logic              ctx_en;

  assign cur_set    = addr_q[SET_W-1:0];
  assign cur_tag    = addr_q[ADDR_W-1:SET_W];
  assign rd_idx     = {probe_q, cur_set};
  assign probe_hit  = (state_q == ST_PROBE) && rd_valid && (rd_tag == cur_tag);
  assign probe_last = (probe_q == WAY_W'(WAYS - 1));
  assign free_seen  = inv_seen_q || !rd_valid;
  assign free_way   = inv_seen_q ? inv_way_q : probe_q;

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    probe_d     = probe_q;
    inv_seen_d  = inv_seen_q;
    inv_way_d   = inv_way_q;
    victim_d    = victim_q;
    use_rr_d    = use_rr_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = rsp_hit_q;
    rsp_data_d  = rsp_data_q;
    rsp_way_d   = rsp_way_q;
    wr_en       = 1'b0;
    rr_adv      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d     = req_addr;
          probe_d    = '0;
          inv_seen_d = 1'b0;
          inv_way_d  = '0;
          state_d    = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (probe_hit) begin
          rsp_valid_d = 1'b1;
          rsp_hit_d   = 1'b1;
          rsp_data_d  = rd_data;
          rsp_way_d   = probe_q;
          state_d     = ST_IDLE;
        end else if (probe_last) begin
          victim_d = free_seen ? free_way : rr_ptr;
          use_rr_d = !free_seen;
          state_d  = ST_FILL;
        end else begin
          probe_d    = probe_q + WAY_W'(1);
          inv_seen_d = free_seen;
          inv_way_d  = free_way;
        end
      end
      ST_FILL: begin
        if (mem_valid) begin
          wr_en       = 1'b1;
          rr_adv      = use_rr_q;
          rsp_valid_d = 1'b1;
          rsp_hit_d   = 1'b0;
          rsp_data_d  = mem_data;
          rsp_way_d   = victim_q;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctx_en  = (state_q != ST_FILL);
  assign wr_idx  = {victim_q, cur_set};
  assign wr_tag  = cur_tag;
  assign wr_data = mem_data;
  assign rr_set  = cur_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      probe_q    <= '0;
      inv_seen_q <= 1'b0;
      inv_way_q  <= '0;
      victim_q   <= '0;
      use_rr_q   <= 1'b0;
    end else if (ctx_en) begin
      addr_q     <= addr_d;
      probe_q    <= probe_d;
      inv_seen_q <= inv_seen_d;
      inv_way_q  <= inv_way_d;
      victim_q   <= victim_d;
      use_rr_q   <= use_rr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit_q  <= 1'b0;
      rsp_data_q <= '0;
      rsp_way_q  <= '0;
    end else if (rsp_valid_d) begin
      rsp_hit_q  <= rsp_hit_d;
      rsp_data_q <= rsp_data_d;
      rsp_way_q  <= rsp_way_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_FILL);
  assign mem_addr  = addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_way   = rsp_way_q;
endmodule

// File: rtl/psa_cache.sv
module psa_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WAYS   = 4,
  localparam int SETS  = LINES / WAYS,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic [SET_W-1:0]  rr_set;
  logic [WAY_W-1:0]  rr_ptr;
  logic              rr_adv;

  psa_line_array #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_core_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  psa_rr_table #(
    .SETS(SETS), .WAYS(WAYS)
  ) u_rr (
    .clk(clk), .rst_n(rst_core_n),
    .set_idx(rr_set), .adv_en(rr_adv), .ptr(rr_ptr)
  );

  psa_probe_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .rr_set(rr_set), .rr_ptr(rr_ptr), .rr_adv(rr_adv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_way(rsp_way)
  );
endmodule

// File: rtl/psa_cache_chk.sv
module psa_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [15:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          busy_cnt_q <= '0;
    else if (req_valid && req_ready)     busy_cnt_q <= '0;
    else if (!req_ready && busy_cnt_q != 16'hFFFF) busy_cnt_q <= busy_cnt_q + 16'd1;
  end

  AST_ONE_SHOT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R3
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (busy_cnt_q == 16'(rsp_way) + 16'd1)); // R2
  AST_FILL_AFTER_ALL_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (busy_cnt_q == 16'(WAYS))); // R4
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R4
  AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R4
endmodule

bind psa_cache psa_cache_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr)
);

// File: tb/psa_cache_bench.sv
`timescale 1ns/1ps
module psa_cache_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WAYS   = 4;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0]        rsp_way;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_valid;
  logic [DATA_W-1:0] mem_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit ready_in_busy;

  psa_cache u_psa_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_way(rsp_way),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mdata(input logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] a, input int delay, input bit inject,
                        output bit hit, output logic [31:0] data, output logic [1:0] way,
                        output int lat, output bit saw_mem, output logic [15:0] maddr,
                        output int mlat);
    int dcnt;
    bit got;
    dcnt = 0; got = 0; saw_mem = 0; maddr = '0; mlat = 0; lat = 0;
    ready_in_busy = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && lat < 100) begin
      if (inject && lat == 0) begin
        req_valid = 1'b1; req_addr = a ^ 16'h0100;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) got = 1;
      else if (req_ready) ready_in_busy = 1;
      if (mem_req && !saw_mem) begin
        saw_mem = 1; maddr = mem_addr; mlat = lat;
      end
      if (mem_req) begin
        if (dcnt == delay) begin
          mem_valid = 1'b1; mem_data = mdata(mem_addr);
        end else dcnt++;
      end else mem_valid = 1'b0;
    end
    hit = rsp_hit; data = rsp_data; way = rsp_way;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response pulse width", 32'(rsp_valid), 0);
  endtask

  task automatic expect_lookup(input logic [15:0] a, input bit exp_hit, input logic [1:0] exp_way,
                               input int delay, input string req);
    bit h; logic [31:0] d; logic [1:0] w; int lat; bit sm; logic [15:0] ma; int ml;
    int exp_lat;
    lookup(a, delay, 1'b0, h, d, w, lat, sm, ma, ml);
    exp_lat = exp_hit ? int'(exp_way) + 1 : WAYS + 1 + delay;
    chk(h == exp_hit, {req, " hit flag"}, 32'(h), 32'(exp_hit));
    chk(w == exp_way, {req, " slot"}, 32'(w), 32'(exp_way));
    chk(d == mdata(a), {req, " data"}, d, mdata(a));
    chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
    chk(ready_in_busy == 1'b0, "R3 ready low while busy", 32'(ready_in_busy), 0);
    if (!exp_hit) begin
      chk(sm && ma == a, "R4 fill address", 32'(ma), 32'(a));
      chk(ml == WAYS, "R4 fill request timing", 32'(ml), 32'(WAYS));
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 no fill after reset", 32'(mem_req), 0);
  endtask

  task automatic t_cold();
    expect_lookup(16'h0003, 1'b0, 2'd0, 0, "R1 R5 R6 cold miss");
    expect_lookup(16'h0003, 1'b1, 2'd0, 0, "R2 R5 hit slot 0");
  endtask

  task automatic t_conflict();
    expect_lookup(16'h0013, 1'b0, 2'd1, 0, "R6 R8 second tag");
    expect_lookup(16'h0023, 1'b0, 2'd2, 0, "R6 R8 third tag");
    expect_lookup(16'h0033, 1'b0, 2'd3, 0, "R6 R8 fourth tag");
    expect_lookup(16'h0033, 1'b1, 2'd3, 0, "R2 hit slot 3");
    expect_lookup(16'h0013, 1'b1, 2'd1, 0, "R2 R8 hit slot 1");
  endtask

  task automatic t_rotate();
    expect_lookup(16'h0043, 1'b0, 2'd0, 0, "R7 rotate first");
    expect_lookup(16'h0053, 1'b0, 2'd1, 0, "R7 rotate second");
    expect_lookup(16'h0003, 1'b0, 2'd2, 0, "R7 evicted refetch");
    expect_lookup(16'h0043, 1'b1, 2'd0, 0, "R7 survivor hit");
  endtask

  task automatic t_isolation();
    for (int i = 0; i < WAYS; i++)
      expect_lookup(16'h0005 + 16'(i * 16), 1'b0, 2'(i), 0, "R6 fill other set");
    expect_lookup(16'h0045, 1'b0, 2'd0, 0, "R7 per-set pointer");
    expect_lookup(16'h0033, 1'b1, 2'd3, 0, "R8 other set untouched");
  endtask

  task automatic t_busy();
    bit h; logic [31:0] d; logic [1:0] w; int lat; bit sm; logic [15:0] ma; int ml;
    int extra;
    lookup(16'h0065, 0, 1'b1, h, d, w, lat, sm, ma, ml);
    chk(h == 1'b0 && w == 2'd1 && d == mdata(16'h0065), "R3 busy request original result", d, mdata(16'h0065));
    extra = 0;
    for (int i = 0; i < WAYS + 3; i++) begin
      @(negedge clk);
      if (rsp_valid || mem_req) extra++;
    end
    chk(extra == 0, "R3 busy request not answered", 32'(extra), 0);
    expect_lookup(16'h0165, 1'b0, 2'd2, 0, "R3 busy address never stored");
  endtask

  task automatic t_stray_fill();
    int extra;
    extra = 0;
    @(negedge clk);
    mem_valid = 1'b1; mem_data = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    mem_valid = 1'b0;
    chk(extra == 0, "R10 stray fill no response", 32'(extra), 0);
    expect_lookup(16'h0035, 1'b1, 2'd3, 0, "R10 line unchanged");
    expect_lookup(16'h0043, 1'b1, 2'd0, 0, "R10 line unchanged");
  endtask

  task automatic t_slow_fill();
    expect_lookup(16'h0007, 1'b0, 2'd0, 5, "R4 R5 delayed fill");
    expect_lookup(16'h0007, 1'b1, 2'd0, 0, "R5 delayed fill stored");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; mem_valid = 1'b0; mem_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cold();
    t_conflict();
    t_rotate();
    t_isolation();
    t_busy();
    t_stray_fill();
    t_slow_fill();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule